// File: doc/BRIEF.md
# Dual Comparator Breakpoint Unit with Masking

This block watches a monitored word, typically an access address, and compares it against four programmable point registers through two comparator channels. Each channel can flag an exact match on either of its two points, or an inclusive range bounded by its two points. Either channel can also apply a bit mask that makes chosen bit positions irrelevant to the comparison. The mask has no register of its own. It is read from one of the point registers, and which point register supplies it depends on which points and ranges are currently in use.

A protection mode changes the kind of indication a hit raises, from a debug break to a protection violation. When the protection mode is combined with a sharing bit, points 2 and 3 define one range that both channels use, and point 0 holds the mask for both. Software programs the points and the control word through a synchronous write port. Each compare strobe produces at most one registered, single-cycle indication per channel.

Top module: `dual_bkpt_unit`

## Requirements
- R1: After reset all four points and the control word are zero and every break output is low. Writes use addresses 0 to 3 for points 0 to 3 and address 4 for the control word. Addresses 5 to 7 are ignored.
- R2: Control bit 0 enables an exact match of channel 0 against point 0, and bit 1 enables one against point 1 (outside the shared mode).
- R3: Control bit 2 enables an exact match of channel 1 against point 2, and bit 3 enables one against point 3 (outside the shared mode).
- R4: Control bit 4 enables a channel 0 range hit when point 0 <= value <= point 1. Control bit 5 enables a channel 1 range hit when point 2 <= value <= point 3. Both bounds are inclusive and the comparison is unsigned.
- R5: When a channel's mask enable is set (bit 6 for channel 0, bit 7 for channel 1), the value and every point that channel uses are ORed with the mask word before comparison. The mask therefore hides the bits that are set in it.
- R6: Channel 0 takes its mask from point 0, or from point 2 when control bit 0 is set.
- R7: Channel 1 takes its mask from point 2, or from point 0 when control bit 2 or control bit 5 is set.
- R8: When control bits 8 (protection) and 9 (share) are both set, both channels ignore their point enables. Each channel then reports a hit only for the range point 2 <= value <= point 3, gated by its own range enable (bit 4 or bit 5), with its mask taken from point 0. Bit 9 alone has no effect.
- R9: A hit appears on the outputs in the cycle after the posedge at which the strobe is sampled high, and lasts exactly one cycle. A cycle without a strobe produces no hit.
- R10: With control bit 8 clear, hits drive dbg_brk[ch]. With bit 8 set, hits drive prot_brk[ch]. The two outputs of one channel are never high together.
- R11: A channel that has no point and no range enabled never reports a hit, whatever its mask enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0-3 points, 4 control) |
| wr_data | input | DW | Write data |
| cmp_vld | input | 1 | Compare strobe |
| cmp_val | input | DW | Monitored value |
| dbg_brk | output | 2 | Per-channel debug break pulse |
| prot_brk | output | 2 | Per-channel protection violation pulse |

## Verification
The bench sweeps every value of the low byte through each configuration and compares the outputs with an arithmetic model. The configurations are chosen so that a misplaced mask source is visible. If channel 0 kept using point 0 as its mask while point 0 was also its compare point, the match set would collapse, and if channel 1 ignored its range enable when choosing its mask, the match set would shift. The inclusive range bounds are covered by the sweep, so an off-by-one comparison loses the end values. The shared mode is checked with point enables still set, so a design that honoured them would flag extra values, and the trailing idle cycle after each sweep catches a hit that is held longer than one cycle.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
   localparam int N_PT     = 4;
   localparam int N_CH     = 2;
   localparam int AW       = 3;
   localparam int CTRL_W   = 10;
   localparam logic [AW-1:0] CTRL_ADDR = 3'd4;

   // control word: bits 9..0 in the field order below
   typedef struct packed {
      logic       share;     // bit 9
      logic       prot;      // bit 8
      logic [1:0] msk_en;    // bits 7:6
      logic [1:0] rng_en;    // bits 5:4
      logic [3:0] pt_en;     // bits 3:0
   } ctrl_t;
endpackage

// File: rtl/dbk_regfile.sv
module dbk_regfile
   import dbk_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [DW-1:0]            wr_data,
   output logic [N_PT-1:0][DW-1:0]  pts,
   output ctrl_t                    ctrl
);
   if (DW < CTRL_W) begin : g_bad_dw
      $error("dbk_regfile: DW must hold the control word");
   end

   for (genvar i = 0; i < N_PT; i++) begin : g_pt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pts[i] <= '0;
         else if (wr_en && wr_addr == AW'(i))
            pts[i] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl <= '0;
      else if (wr_en && wr_addr == CTRL_ADDR)
         ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   // R1: an out-of-map write leaves the control word alone
   a_r1_bad_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr > CTRL_ADDR) |=> $stable(ctrl));
endmodule

// File: rtl/dbk_mask_sel.sv
module dbk_mask_sel
   import dbk_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [N_PT-1:0][DW-1:0]  pts,
   input  logic                     shared,
   input  logic                     pt0_en,
   input  logic                     pt2_en,
   input  logic                     rng1_en,
   input  logic [N_CH-1:0]          msk_en,
   output logic [N_CH-1:0][DW-1:0]  mask
);
   logic [N_CH-1:0][DW-1:0] src;

   always_comb begin
      // channel 0: point 0 by default, moves to point 2 once point 0 is claimed
      if (shared)      src[0] = pts[0];
      else if (pt0_en) src[0] = pts[2];
      else             src[0] = pts[0];
      // channel 1: point 2 by default, moves to point 0 once point 2 is claimed
      if (shared)                src[1] = pts[0];
      else if (pt2_en || rng1_en) src[1] = pts[0];
      else                        src[1] = pts[2];
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_gate
      assign mask[c] = msk_en[c] ? src[c] : '0;
   end
endmodule

// File: rtl/dbk_channel.sv
module dbk_channel #(
   parameter int DW        = 32,
   parameter bit HAS_RANGE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmp_vld,
   input  logic [DW-1:0] cmp_val,
   input  logic [DW-1:0] lo_pt,
   input  logic [DW-1:0] hi_pt,
   input  logic [DW-1:0] mask,
   input  logic          lo_en,
   input  logic          hi_en,
   input  logic          rng_en,
   input  logic          prot_mode,
   output logic          dbg_o,
   output logic          prot_o
);
   logic [DW-1:0] v_m, lo_m, hi_m;
   logic          pt_hit, rng_hit, hit;

   always_comb begin
      v_m    = cmp_val | mask;
      lo_m   = lo_pt   | mask;
      hi_m   = hi_pt   | mask;
      pt_hit = (lo_en && v_m == lo_m) || (hi_en && v_m == hi_m);
   end

   if (HAS_RANGE) begin : g_range
      assign rng_hit = rng_en && (v_m >= lo_m) && (v_m <= hi_m);
   end else begin : g_no_range
      assign rng_hit = 1'b0;
   end

   assign hit = cmp_vld && (pt_hit || rng_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbg_o  <= 1'b0;
         prot_o <= 1'b0;
      end else begin
         dbg_o  <= hit && !prot_mode;
         prot_o <= hit &&  prot_mode;
      end
   end

   // R9: no strobe, no indication next cycle
   a_r9_no_strobe_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_vld |=> !(dbg_o || prot_o));
   // R11: nothing enabled, nothing reported
   a_r11_idle_channel: assert property (@(posedge clk) disable iff (!rst_n)
      !(lo_en || hi_en || rng_en) |=> !(dbg_o || prot_o));
   // R10: indication kind follows the protection bit
   a_r10_kind_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dbg_o, prot_o}));
   a_r10_debug_kind: assert property (@(posedge clk) disable iff (!rst_n)
      !prot_mode |=> !prot_o);
   // R4: unmasked in-range strobe must report
   a_r4_inclusive_range: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_RANGE && cmp_vld && rng_en && mask == '0 &&
       cmp_val >= lo_pt && cmp_val <= hi_pt) |=> (dbg_o || prot_o));
endmodule

// File: rtl/dual_bkpt_unit.sv
module dual_bkpt_unit
   import dbk_pkg::*;
#(
   parameter int DW        = 32,
   parameter bit HAS_RANGE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          cmp_vld,
   input  logic [DW-1:0] cmp_val,
   output logic [1:0]    dbg_brk,
   output logic [1:0]    prot_brk
);
   if (DW < CTRL_W) begin : g_bad_dw
      $error("dual_bkpt_unit: DW too small for the control word");
   end

   logic [N_PT-1:0][DW-1:0] pts;
   ctrl_t                   ctrl;
   logic                    shared;
   logic [N_CH-1:0][DW-1:0] mask;

   dbk_regfile #(.DW(DW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pts     (pts),
      .ctrl    (ctrl)
   );

   assign shared = ctrl.prot && ctrl.share;

   dbk_mask_sel #(.DW(DW)) u_mask (
      .pts     (pts),
      .shared  (shared),
      .pt0_en  (ctrl.pt_en[0]),
      .pt2_en  (ctrl.pt_en[2]),
      .rng1_en (ctrl.rng_en[1]),
      .msk_en  (ctrl.msk_en),
      .mask    (mask)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic [DW-1:0] lo_pt, hi_pt;
      logic          lo_en, hi_en;

      assign lo_pt = shared ? pts[2] : pts[2*c];
      assign hi_pt = shared ? pts[3] : pts[2*c+1];
      assign lo_en = !shared && ctrl.pt_en[2*c];
      assign hi_en = !shared && ctrl.pt_en[2*c+1];

      dbk_channel #(.DW(DW), .HAS_RANGE(HAS_RANGE)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .cmp_vld   (cmp_vld),
         .cmp_val   (cmp_val),
         .lo_pt     (lo_pt),
         .hi_pt     (hi_pt),
         .mask      (mask[c]),
         .lo_en     (lo_en),
         .hi_en     (hi_en),
         .rng_en    (ctrl.rng_en[c]),
         .prot_mode (ctrl.prot),
         .dbg_o     (dbg_brk[c]),
         .prot_o    (prot_brk[c])
      );
   end

   // R8: in the shared mode, identical enables give identical verdicts
   a_r8_shared_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (shared && ctrl.rng_en == 2'b11 && ctrl.msk_en[0] == ctrl.msk_en[1])
      |=> (prot_brk[0] == prot_brk[1]));
endmodule

// File: tb/dual_bkpt_unit_bench.sv
module dual_bkpt_unit_bench;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          cmp_vld = 1'b0;
   logic [DW-1:0] cmp_val = '0;
   logic [1:0]    dbg_brk, prot_brk;

   int total = 0;
   int bad   = 0;

   logic [DW-1:0] p [4];
   logic [DW-1:0] c;

   always #5 clk = ~clk;

   dual_bkpt_unit #(.DW(DW)) u_dual_bkpt_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cmp_vld(cmp_vld), .cmp_val(cmp_val),
      .dbg_brk(dbg_brk), .prot_brk(prot_brk)
   );

   task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a < 4) p[a] = d;
      else if (a == 4) c = d;
   endtask

   // expected {prot_brk, dbg_brk} for one strobe, derived from R2..R11
   function automatic logic [3:0] model(input logic [DW-1:0] v);
      logic          sh;
      logic [1:0]    h;
      logic [DW-1:0] m, lo, hi, vm;
      logic          le, he, re;
      sh = c[8] & c[9];
      for (int ch = 0; ch < 2; ch++) begin
         if (sh)       m = p[0];
         else if (ch == 0) m = c[0] ? p[2] : p[0];
         else          m = (c[2] | c[5]) ? p[0] : p[2];
         if (!c[6+ch]) m = '0;
         lo = sh ? p[2] : p[2*ch];
         hi = sh ? p[3] : p[2*ch+1];
         le = !sh && c[2*ch];
         he = !sh && c[2*ch+1];
         re = c[4+ch];
         vm = v | m;
         h[ch] = (le && vm == (lo | m)) || (he && vm == (hi | m)) ||
                 (re && vm >= (lo | m) && vm <= (hi | m));
      end
      return c[8] ? {h, 2'b00} : {2'b00, h};
   endfunction

   task automatic sweep(input string tag);
      for (int v = 0; v < 256; v++) begin
         cmp_vld = 1'b1; cmp_val = DW'(v);
         @(negedge clk);
         check({prot_brk, dbg_brk}, model(DW'(v)), tag);
      end
      cmp_vld = 1'b0;
      @(negedge clk);
      check({prot_brk, dbg_brk}, 4'b0000, "R9 idle after strobe");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) p[i] = '0;
      c = '0;
      repeat (3) @(negedge clk);
      check({prot_brk, dbg_brk}, 4'b0000, "R1 reset outputs");
      rst_n = 1'b1;
      @(negedge clk);
      sweep("R1 cleared registers");
      wr(4, 16'h00C0); sweep("R11 mask only");
      wr(5, 16'h000F); wr(7, 16'h00FF); sweep("R1 ignored addresses");
      wr(0, 16'h0035); wr(1, 16'h0080); wr(4, 16'h0003); sweep("R2 points 0/1");
      wr(2, 16'h0011); wr(3, 16'h00FE); wr(4, 16'h000C); sweep("R3 points 2/3");
      wr(0, 16'h0020); wr(1, 16'h0040); wr(2, 16'h0090); wr(3, 16'h00A0);
      wr(4, 16'h0030); sweep("R4 ranges");
      wr(0, 16'h000F); wr(1, 16'h0053); wr(4, 16'h0042); sweep("R5 R6 mask in point 0");
      wr(0, 16'h0044); wr(2, 16'h0003); wr(4, 16'h0041); sweep("R6 mask moved to point 2");
      wr(2, 16'h00F0); wr(3, 16'h0037); wr(4, 16'h0088); sweep("R7 mask in point 2");
      wr(0, 16'h000C); wr(2, 16'h0040); wr(3, 16'h0060); wr(4, 16'h00A0);
      sweep("R7 mask moved to point 0");
      wr(0, 16'h0001); wr(2, 16'h0010); wr(3, 16'h0031); wr(4, 16'h0371);
      sweep("R8 shared range");
      wr(0, 16'h0035); wr(1, 16'h0080); wr(4, 16'h0203); sweep("R8 share bit alone");
      wr(0, 16'h0044); wr(4, 16'h0101); sweep("R10 protection kind");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule